// File: doc/BRIEF.md
# UART Holding Path Ready and Interrupt Signalling

This block is the byte-holding core of one UART channel. It keeps a transmit queue and a receive queue. Each queue holds up to 16 bytes when the queues are enabled, and a single byte when they are disabled. It sits between a host that writes transmit bytes and reads received bytes, and a serializer pair that pushes received bytes in and pops transmit bytes out. A receive time-out pulse comes from outside.

From the fill levels and an 8-bit control word it drives two active-low transfer-ready outputs, one for each direction. It also drives one active-high interrupt and the two transmitter-empty status bits. The ready outputs follow three rule sets: queues off, queues on in single-character mode, and queues on in block mode. In block mode the receive-ready output is a latched flag. The flag sets when the receive level reaches the programmed trigger or when a time-out arrives while data is held. It releases only when the receive queue drains to empty.

The control word is decoded as follows. Bit 0 enables the queues. Bit 1 flushes the receive queue and bit 2 flushes the transmit queue; both flush bits act once and are not stored. Bit 3 selects block mode. Bits 7:6 select the receive trigger level.

Top module: `uart_hold_path`

## Requirements
- R1: After reset the queues are disabled and empty, rx_rdy_n=1, tx_rdy_n=0, irq=1, thr_empty=1, tx_idle=1 and rx_overrun=0.
- R2: With control bit 0 clear, each direction holds one byte. rx_rdy_n is 0 while a received byte is held and 1 otherwise. tx_rdy_n is 1 while a transmit byte is held and 0 when the holding register is empty.
- R3: With bit 0 set and bit 3 clear, rx_rdy_n is 0 whenever the receive queue holds at least one byte. tx_rdy_n is 1 whenever the transmit queue holds any byte and 0 only when it is empty.
- R4: With bits 0 and 3 set, rx_rdy_n falls when the receive level reaches the trigger, or on ser_rx_timeout while data is held. It stays 0 as bytes are read and rises only when the receive queue becomes empty.
- R5: With bits 0 and 3 set, tx_rdy_n is 1 only when the transmit queue holds 16 bytes. A host write into a full transmit queue is discarded.
- R6: Control bits 7:6 set the receive trigger: 00=1, 01=4, 10=8, 11=14 bytes.
- R7: irq is 1 when the transmit side is empty, or when the receive level is at or above the trigger. The trigger is 1 byte when the queues are disabled. Otherwise irq is 0.
- R8: thr_empty is 1 exactly when no transmit byte is held. tx_idle is 1 when thr_empty is 1 and ser_busy is 0.
- R9: A control write with bit 1 set empties the receive queue, and one with bit 2 set empties the transmit queue. A write that changes bit 0 empties both queues. The flush wins over a push in the same cycle. Outputs reflect the flush one clock later.
- R10: A receive push into a full queue is discarded and sets rx_overrun, which stays set until a receive flush. A host read of an empty receive queue leaves the level unchanged and host_rx_data holding its last value.
- R11: Bytes leave each queue in arrival order. host_rx_data and ser_tx_data show the byte in the cycle after the read or pop that took it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ctl_wr | input | 1 | Control word write strobe |
| ctl_wdata | input | 8 | Control word value |
| host_tx_wr | input | 1 | Host writes a transmit byte |
| host_tx_data | input | 8 | Transmit byte from host |
| host_rx_rd | input | 1 | Host reads a received byte |
| host_rx_data | output | 8 | Last byte read from the receive side |
| ser_rx_push | input | 1 | Deserializer delivers a byte |
| ser_rx_data | input | 8 | Byte from deserializer |
| ser_rx_timeout | input | 1 | Receive time-out pulse |
| ser_tx_pop | input | 1 | Serializer takes a transmit byte |
| ser_tx_data | output | 8 | Last byte taken by the serializer |
| ser_busy | input | 1 | Serializer is still shifting |
| rx_rdy_n | output | 1 | Receive transfer ready, active low |
| tx_rdy_n | output | 1 | Transmit transfer ready, active low |
| irq | output | 1 | Interrupt, active high |
| thr_empty | output | 1 | No transmit byte held |
| tx_idle | output | 1 | Transmit side and serializer empty |
| rx_overrun | output | 1 | Sticky receive overrun |

## Verification
Every output is a register loaded from the next-state fill levels and control word. A stimulus sampled at one rising edge therefore appears on all outputs just after that same edge, including data, status, ready, interrupt and flush effects. The bench drives every input on the falling edge and releases pulses on the next falling edge. It checks there, exactly one rising edge after the stimulus. Hysteresis and order tests are walked one cycle at a time, so each intermediate level is checked at that level.

// File: rtl/xsig_pkg.sv
// Shared definitions for the UART holding path.
// Assumes: trigger encodings only reach depths of 14 or more.
package xsig_pkg;

    typedef enum logic [1:0] {
        XM_OFF    = 2'd0,
        XM_SINGLE = 2'd1,
        XM_BLOCK  = 2'd2
    } xfer_mode_e;

    // Map the two trigger select bits to a byte count.
    function automatic int unsigned trig_bytes(input logic [1:0] sel);
        case (sel)
            2'b00:   return 1;
            2'b01:   return 4;
            2'b10:   return 8;
            default: return 14;
        endcase
    endfunction

endpackage

// File: rtl/xsig_ctl.sv
// Control word register and decode.
// Stores enable, block-mode and trigger select. Produces one-shot flush
// strobes and the next-state mode and trigger used by the registered outputs.
// Assumes: the control write is a single-cycle strobe.
module xsig_ctl
    import xsig_pkg::*;
#(
    parameter int LVL_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [7:0]       wdata,
    output logic             en_q,
    output logic             blk_q,
    output xfer_mode_e       mode_nxt,
    output logic [LVL_W-1:0] trig_nxt,
    output logic             clr_rx,
    output logic             clr_tx
);

    logic [1:0] sel_q;
    logic       en_nxt;
    logic       blk_nxt;
    logic [1:0] sel_nxt;
    logic       en_flip;

    // Store the persistent control fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q  <= 1'b0;
            blk_q <= 1'b0;
            sel_q <= 2'b00;
        end else if (wr) begin
            en_q  <= wdata[0];
            blk_q <= wdata[3];
            sel_q <= wdata[7:6];
        end
    end

    // Decode next-state fields, flush strobes, mode and trigger.
    always_comb begin
        en_nxt  = wr ? wdata[0]   : en_q;
        blk_nxt = wr ? wdata[3]   : blk_q;
        sel_nxt = wr ? wdata[7:6] : sel_q;
        en_flip = wr && (wdata[0] != en_q);
        clr_rx  = (wr && wdata[1]) || en_flip;
        clr_tx  = (wr && wdata[2]) || en_flip;
        if (!en_nxt) begin
            mode_nxt = XM_OFF;
        end else if (blk_nxt) begin
            mode_nxt = XM_BLOCK;
        end else begin
            mode_nxt = XM_SINGLE;
        end
        trig_nxt = en_nxt ? LVL_W'(trig_bytes(sel_nxt)) : LVL_W'(1);
    end

endmodule

// File: rtl/xsig_fifo.sv
// Byte queue with a run-time capacity limit.
// Circular buffer of DEPTH entries. The usable capacity comes in on cap, so
// the same storage serves as a one-byte holding register. Push into a full
// queue and pop from an empty queue are refused; flush wins over both.
// Exposes the registered level and its next-state value.
// Assumes: 1 <= cap <= DEPTH, DEPTH >= 2.
module xsig_fifo #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 16,
    parameter int LVL_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic [LVL_W-1:0]  cap,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    output logic [DATA_W-1:0] pop_data,
    output logic [LVL_W-1:0]  level,
    output logic [LVL_W-1:0]  level_nxt
);

    localparam int PTR_W = $clog2(DEPTH);
    localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wr_ptr;
    logic [PTR_W-1:0]  rd_ptr;
    logic              push_ok;
    logic              pop_ok;

    // Decide which requests are taken and form the next level.
    always_comb begin
        push_ok   = push && !clr && (level < cap);
        pop_ok    = pop && !clr && (level != '0);
        level_nxt = level;
        if (clr) begin
            level_nxt = '0;
        end else if (push_ok && !pop_ok) begin
            level_nxt = level + LVL_W'(1);
        end else if (pop_ok && !push_ok) begin
            level_nxt = level - LVL_W'(1);
        end
    end

    // Write accepted bytes into storage.
    always_ff @(posedge clk) begin
        if (push_ok) begin
            mem[wr_ptr] <= push_data;
        end
    end

    // Advance pointers, level and the output byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr   <= '0;
            rd_ptr   <= '0;
            level    <= '0;
            pop_data <= '0;
        end else begin
            level <= level_nxt;
            if (clr) begin
                wr_ptr <= '0;
                rd_ptr <= '0;
            end else begin
                if (push_ok) begin
                    wr_ptr <= (wr_ptr == PTR_LAST) ? '0 : wr_ptr + PTR_W'(1);
                end
                if (pop_ok) begin
                    rd_ptr   <= (rd_ptr == PTR_LAST) ? '0 : rd_ptr + PTR_W'(1);
                    pop_data <= mem[rd_ptr];
                end
            end
        end
    end

endmodule

// File: rtl/xsig_flags.sv
// Registered ready, interrupt and status outputs.
// Every output is loaded from next-state levels and mode, so it changes at
// the same edge as the queue it describes. Keeps the block-mode receive
// flag, which sets at the trigger or on a time-out and clears on empty.
// Assumes: trigger is nonzero and levels never exceed DEPTH.
module xsig_flags
    import xsig_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  xfer_mode_e       mode_nxt,
    input  logic [LVL_W-1:0] trig_nxt,
    input  logic [LVL_W-1:0] rx_lvl_nxt,
    input  logic [LVL_W-1:0] tx_lvl_nxt,
    input  logic             rx_timeout,
    input  logic             ser_busy,
    input  logic             rx_drop,
    input  logic             clr_rx,
    output logic             rx_rdy_n,
    output logic             tx_rdy_n,
    output logic             irq,
    output logic             thr_empty,
    output logic             tx_idle,
    output logic             rx_overrun
);

    localparam logic [LVL_W-1:0] LVL_FULL = LVL_W'(DEPTH);

    logic blk_flag_q;
    logic blk_flag_nxt;
    logic rx_has;
    logic tx_has;
    logic rx_at_trig;
    logic rx_rdy_n_nxt;
    logic tx_rdy_n_nxt;
    logic ovr_nxt;

    // Derive next-state output values from the next levels and mode.
    always_comb begin
        rx_has     = (rx_lvl_nxt != '0);
        tx_has     = (tx_lvl_nxt != '0);
        rx_at_trig = (rx_lvl_nxt >= trig_nxt);
        if (!rx_has) begin
            blk_flag_nxt = 1'b0;
        end else if (rx_at_trig || rx_timeout) begin
            blk_flag_nxt = 1'b1;
        end else begin
            blk_flag_nxt = blk_flag_q;
        end
        if (mode_nxt == XM_BLOCK) begin
            rx_rdy_n_nxt = !blk_flag_nxt;
            tx_rdy_n_nxt = (tx_lvl_nxt == LVL_FULL);
        end else begin
            rx_rdy_n_nxt = !rx_has;
            tx_rdy_n_nxt = tx_has;
        end
        if (clr_rx) begin
            ovr_nxt = 1'b0;
        end else begin
            ovr_nxt = rx_overrun || rx_drop;
        end
    end

    // Register every output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            blk_flag_q <= 1'b0;
            rx_rdy_n   <= 1'b1;
            tx_rdy_n   <= 1'b0;
            irq        <= 1'b1;
            thr_empty  <= 1'b1;
            tx_idle    <= 1'b1;
            rx_overrun <= 1'b0;
        end else begin
            blk_flag_q <= blk_flag_nxt;
            rx_rdy_n   <= rx_rdy_n_nxt;
            tx_rdy_n   <= tx_rdy_n_nxt;
            irq        <= !tx_has || rx_at_trig;
            thr_empty  <= !tx_has;
            tx_idle    <= !tx_has && !ser_busy;
            rx_overrun <= ovr_nxt;
        end
    end

endmodule

// File: rtl/uart_hold_path.sv
// UART channel holding path: transmit and receive queues with ready,
// interrupt and status signalling.
// Joins the control decode, two capacity-limited queues and the output
// register stage. With the queues disabled each queue is capped at one byte.
// Assumes: all strobes are single-cycle and synchronous to clk.
module uart_hold_path
    import xsig_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_wr,
    input  logic [7:0]        ctl_wdata,
    input  logic              host_tx_wr,
    input  logic [DATA_W-1:0] host_tx_data,
    input  logic              host_rx_rd,
    output logic [DATA_W-1:0] host_rx_data,
    input  logic              ser_rx_push,
    input  logic [DATA_W-1:0] ser_rx_data,
    input  logic              ser_rx_timeout,
    input  logic              ser_tx_pop,
    output logic [DATA_W-1:0] ser_tx_data,
    input  logic              ser_busy,
    output logic              rx_rdy_n,
    output logic              tx_rdy_n,
    output logic              irq,
    output logic              thr_empty,
    output logic              tx_idle,
    output logic              rx_overrun
);

    localparam int LVL_W = $clog2(DEPTH + 1);

    logic             en_q;
    logic             blk_q;
    xfer_mode_e       mode_nxt;
    logic [LVL_W-1:0] trig_nxt;
    logic             clr_rx;
    logic             clr_tx;
    logic [LVL_W-1:0] cap;
    logic [LVL_W-1:0] rx_lvl;
    logic [LVL_W-1:0] rx_lvl_nxt;
    logic [LVL_W-1:0] tx_lvl;
    logic [LVL_W-1:0] tx_lvl_nxt;
    logic             rx_drop;

    // Queue capacity and receive overrun detection.
    always_comb begin
        cap     = en_q ? LVL_W'(DEPTH) : LVL_W'(1);
        rx_drop = ser_rx_push && !clr_rx && (rx_lvl == cap);
    end

    xsig_ctl #(.LVL_W(LVL_W)) u_ctl (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (ctl_wr),
        .wdata    (ctl_wdata),
        .en_q     (en_q),
        .blk_q    (blk_q),
        .mode_nxt (mode_nxt),
        .trig_nxt (trig_nxt),
        .clr_rx   (clr_rx),
        .clr_tx   (clr_tx)
    );

    xsig_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH), .LVL_W(LVL_W)) u_rxq (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (clr_rx),
        .cap       (cap),
        .push      (ser_rx_push),
        .push_data (ser_rx_data),
        .pop       (host_rx_rd),
        .pop_data  (host_rx_data),
        .level     (rx_lvl),
        .level_nxt (rx_lvl_nxt)
    );

    xsig_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH), .LVL_W(LVL_W)) u_txq (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (clr_tx),
        .cap       (cap),
        .push      (host_tx_wr),
        .push_data (host_tx_data),
        .pop       (ser_tx_pop),
        .pop_data  (ser_tx_data),
        .level     (tx_lvl),
        .level_nxt (tx_lvl_nxt)
    );

    xsig_flags #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_nxt   (mode_nxt),
        .trig_nxt   (trig_nxt),
        .rx_lvl_nxt (rx_lvl_nxt),
        .tx_lvl_nxt (tx_lvl_nxt),
        .rx_timeout (ser_rx_timeout),
        .ser_busy   (ser_busy),
        .rx_drop    (rx_drop),
        .clr_rx     (clr_rx),
        .rx_rdy_n   (rx_rdy_n),
        .tx_rdy_n   (tx_rdy_n),
        .irq        (irq),
        .thr_empty  (thr_empty),
        .tx_idle    (tx_idle),
        .rx_overrun (rx_overrun)
    );

endmodule

// File: rtl/xsig_checker.sv
// Property checker for the UART holding path, attached by bind.
// Relates registered outputs to queue levels and control state.
// Assumes: levels and control flags come from the bound top.
module xsig_checker #(
    parameter int DEPTH = 16,
    parameter int LVL_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ctl_wr,
    input logic [7:0]       ctl_wdata,
    input logic             ser_rx_push,
    input logic             rx_rdy_n,
    input logic             tx_rdy_n,
    input logic             irq,
    input logic             thr_empty,
    input logic             tx_idle,
    input logic             rx_overrun,
    input logic             en_q,
    input logic             blk_q,
    input logic [LVL_W-1:0] rx_lvl,
    input logic [LVL_W-1:0] tx_lvl
);

    AST_EMPTY_TX_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        thr_empty |-> irq); // R7
    AST_IDLE_NEEDS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        tx_idle |-> thr_empty); // R8
    AST_BLOCK_RX_EMPTY_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q && blk_q && rx_lvl == '0) |-> rx_rdy_n); // R4
    AST_BLOCK_TX_FULL_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q && blk_q) |-> (tx_rdy_n == (tx_lvl == LVL_W'(DEPTH)))); // R5
    AST_RX_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && ctl_wdata[1]) |=> (rx_lvl == '0)); // R9
    AST_OVERRUN_FROM_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_overrun) |-> $past(ser_rx_push)); // R10
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_lvl <= LVL_W'(DEPTH)) && (tx_lvl <= LVL_W'(DEPTH))); // R10

endmodule

bind uart_hold_path xsig_checker #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ctl_wr      (ctl_wr),
    .ctl_wdata   (ctl_wdata),
    .ser_rx_push (ser_rx_push),
    .rx_rdy_n    (rx_rdy_n),
    .tx_rdy_n    (tx_rdy_n),
    .irq         (irq),
    .thr_empty   (thr_empty),
    .tx_idle     (tx_idle),
    .rx_overrun  (rx_overrun),
    .en_q        (en_q),
    .blk_q       (blk_q),
    .rx_lvl      (rx_lvl),
    .tx_lvl      (tx_lvl)
);

// File: tb/uart_hold_path_tb_top.sv
`timescale 1ns/1ps
module uart_hold_path_tb_top;

    localparam logic [2:0] OP_NOP = 3'd0, OP_CTL = 3'd1, OP_RXP = 3'd2, OP_RXR = 3'd3,
                           OP_TXW = 3'd4, OP_TXP = 3'd5, OP_TMO = 3'd6;

    // {op, data, expected rx_rdy_n, tx_rdy_n, irq}
    localparam logic [13:0] VEC [10] = '{
        {OP_CTL, 8'h01, 3'b101},   // R3 enable, single mode, trigger 1
        {OP_RXP, 8'h11, 3'b001},   // R3 rx byte held
        {OP_TXW, 8'h22, 3'b011},   // R3 tx byte held
        {OP_RXR, 8'h00, 3'b110},   // R7 rx empty, tx busy
        {OP_TXP, 8'h00, 3'b101},   // R3 tx drained
        {OP_CTL, 8'h49, 3'b101},   // R6 block mode, trigger 4
        {OP_RXP, 8'h44, 3'b101},   // R4 below trigger
        {OP_TXW, 8'h33, 3'b100},   // R5 not full, R7 irq low
        {OP_TMO, 8'h00, 3'b000},   // R4 time-out sets ready
        {OP_RXR, 8'h00, 3'b100}    // R4 empty releases
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctl_wr = 1'b0;
    logic [7:0] ctl_wdata = '0;
    logic       host_tx_wr = 1'b0;
    logic [7:0] host_tx_data = '0;
    logic       host_rx_rd = 1'b0;
    logic [7:0] host_rx_data;
    logic       ser_rx_push = 1'b0;
    logic [7:0] ser_rx_data = '0;
    logic       ser_rx_timeout = 1'b0;
    logic       ser_tx_pop = 1'b0;
    logic [7:0] ser_tx_data;
    logic       ser_busy = 1'b0;
    logic       rx_rdy_n, tx_rdy_n, irq, thr_empty, tx_idle, rx_overrun;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    uart_hold_path dut_i (
        .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
        .host_tx_wr(host_tx_wr), .host_tx_data(host_tx_data),
        .host_rx_rd(host_rx_rd), .host_rx_data(host_rx_data),
        .ser_rx_push(ser_rx_push), .ser_rx_data(ser_rx_data),
        .ser_rx_timeout(ser_rx_timeout), .ser_tx_pop(ser_tx_pop),
        .ser_tx_data(ser_tx_data), .ser_busy(ser_busy),
        .rx_rdy_n(rx_rdy_n), .tx_rdy_n(tx_rdy_n), .irq(irq),
        .thr_empty(thr_empty), .tx_idle(tx_idle), .rx_overrun(rx_overrun)
    );

    task automatic chk(input string req, input string what, input logic [7:0] act,
                       input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic chk_rti(input string req, input logic [2:0] exp);
        chk(req, "rx_rdy_n,tx_rdy_n,irq", {5'd0, rx_rdy_n, tx_rdy_n, irq}, {5'd0, exp});
    endtask

    // Drive one operation at a falling edge; return at the next falling edge.
    task automatic op(input logic [2:0] code, input logic [7:0] d);
        case (code)
            OP_CTL: begin ctl_wr = 1'b1; ctl_wdata = d; end
            OP_RXP: begin ser_rx_push = 1'b1; ser_rx_data = d; end
            OP_RXR: host_rx_rd = 1'b1;
            OP_TXW: begin host_tx_wr = 1'b1; host_tx_data = d; end
            OP_TXP: ser_tx_pop = 1'b1;
            OP_TMO: ser_rx_timeout = 1'b1;
            default: ;
        endcase
        @(negedge clk);
        ctl_wr = 1'b0; ser_rx_push = 1'b0; host_rx_rd = 1'b0;
        host_tx_wr = 1'b0; ser_tx_pop = 1'b0; ser_rx_timeout = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog (all requirements): actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk_rti("R1", 3'b101);
        chk("R1", "thr_empty,tx_idle,ovr", {5'd0, thr_empty, tx_idle, rx_overrun}, 8'h06);

        // Vector table
        for (int i = 0; i < 10; i++) begin
            op(VEC[i][13:11], VEC[i][10:3]);
            chk_rti($sformatf("R3/R4/R5/R6/R7 vec%0d", i), VEC[i][2:0]);
        end

        // R4/R6: trigger 8 hysteresis; flush tx first (R9)
        op(OP_CTL, 8'h8D);
        chk_rti("R9 tx flush", 3'b101);
        for (int k = 0; k < 7; k++) op(OP_RXP, 8'hB0 + 8'(k));
        chk_rti("R6 below trigger 8", 3'b101);
        op(OP_RXP, 8'hB7);
        chk_rti("R4 trigger 8 reached", 3'b001);
        op(OP_RXR, 8'h00);
        chk_rti("R4 stays low at 7", 3'b001);
        chk("R11", "first rx byte", host_rx_data, 8'hB0);
        for (int k = 1; k < 7; k++) begin
            op(OP_RXR, 8'h00);
            chk("R11", "rx order", host_rx_data, 8'hB0 + 8'(k));
        end
        chk_rti("R4 stays low at 1", 3'b001);
        op(OP_RXR, 8'h00);
        chk_rti("R4 releases on empty", 3'b101);

        // R6/R7: trigger 14 with a tx byte held
        op(OP_CTL, 8'hC9);
        op(OP_TXW, 8'h55);
        for (int k = 0; k < 13; k++) op(OP_RXP, 8'(k));
        chk_rti("R7 rx 13 below 14", 3'b100);
        op(OP_RXP, 8'h0D);
        chk_rti("R6 trigger 14", 3'b001);
        op(OP_CTL, 8'hCB);
        chk_rti("R9 rx flush", 3'b100);

        // R5: block tx full
        op(OP_CTL, 8'hCD);
        for (int k = 0; k < 15; k++) op(OP_TXW, 8'hA0 + 8'(k));
        chk("R5", "tx_rdy_n at 15", {7'd0, tx_rdy_n}, 8'h00);
        op(OP_TXW, 8'hAF);
        chk("R5", "tx_rdy_n at 16", {7'd0, tx_rdy_n}, 8'h01);
        op(OP_TXW, 8'hEE);
        chk("R5", "tx_rdy_n after refused write", {7'd0, tx_rdy_n}, 8'h01);
        op(OP_TXP, 8'h00);
        chk("R5", "tx_rdy_n at 15 again", {7'd0, tx_rdy_n}, 8'h00);
        chk("R11", "first tx byte", ser_tx_data, 8'hA0);
        for (int k = 1; k < 16; k++) begin
            op(OP_TXP, 8'h00);
            chk("R11", "tx order", ser_tx_data, 8'hA0 + 8'(k));
        end
        chk("R8", "thr_empty after drain", {7'd0, thr_empty}, 8'h01);

        // R8: status with serializer busy
        ser_busy = 1'b1;
        op(OP_NOP, 8'h00);
        chk("R8", "idle,empty busy", {6'd0, tx_idle, thr_empty}, 8'h01);
        op(OP_TXW, 8'h77);
        chk("R8", "idle,empty held", {6'd0, tx_idle, thr_empty}, 8'h00);
        op(OP_TXP, 8'h00);
        chk("R8", "idle,empty popped busy", {6'd0, tx_idle, thr_empty}, 8'h01);
        ser_busy = 1'b0;
        op(OP_NOP, 8'h00);
        chk("R8", "idle,empty free", {6'd0, tx_idle, thr_empty}, 8'h03);

        // R3: single mode without flush
        op(OP_CTL, 8'h01);
        op(OP_TXW, 8'h01);
        op(OP_TXW, 8'h02);
        op(OP_RXP, 8'h03);
        chk_rti("R3 single tx 2 rx 1", 3'b011);
        op(OP_CTL, 8'h07);
        chk_rti("R9 both flush", 3'b101);

        // R9: flush wins over same-cycle push
        ser_rx_push = 1'b1; ser_rx_data = 8'h99;
        op(OP_CTL, 8'h03);
        chk_rti("R9 flush beats push", 3'b101);

        // R2/R10: queues disabled (enable change flushes)
        op(OP_CTL, 8'h00);
        op(OP_RXP, 8'h61);
        chk_rti("R2 rx held", 3'b001);
        chk("R10", "no overrun yet", {7'd0, rx_overrun}, 8'h00);
        op(OP_RXP, 8'h62);
        chk("R10", "overrun set", {7'd0, rx_overrun}, 8'h01);
        op(OP_TXW, 8'h71);
        op(OP_TXW, 8'h72);
        chk_rti("R2 tx held", 3'b011);
        op(OP_RXR, 8'h00);
        chk("R2", "rx data kept first", host_rx_data, 8'h61);
        chk_rti("R2 rx empty", 3'b110);
        op(OP_RXR, 8'h00);
        chk("R10", "empty read keeps data", host_rx_data, 8'h61);
        op(OP_RXP, 8'h63);
        chk_rti("R10 level not wrapped", 3'b011);
        op(OP_RXR, 8'h00);
        chk("R10", "next read", host_rx_data, 8'h63);
        op(OP_TXP, 8'h00);
        chk("R2", "tx kept first", ser_tx_data, 8'h71);
        chk_rti("R2 tx empty", 3'b101);
        op(OP_CTL, 8'h02);
        chk("R10", "overrun cleared by flush", {7'd0, rx_overrun}, 8'h00);
        op(OP_TXW, 8'h10);
        op(OP_RXP, 8'h20);
        chk_rti("R7 off mode rx byte", 3'b011);
        op(OP_RXR, 8'h00);
        chk_rti("R7 off mode no rx", 3'b110);

        // R1: mid-run reset
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk_rti("R1 after second reset", 3'b101);
        chk("R1", "thr_empty,tx_idle,ovr", {5'd0, thr_empty, tx_idle, rx_overrun}, 8'h06);

        finish_run();
    end

endmodule